// File: doc/BRIEF.md
# Slave-FIFO Transfer Engine

This block sits on the programmable-logic side of a USB microcontroller that exposes two byte-wide FIFOs in synchronous mode: one filled by the host (host-to-fabric) and one drained by the host (fabric-to-host). It pops a one-byte header that gives the transfer direction and a channel number, then a four-byte transfer length with the most significant byte first. It then moves exactly that many data bytes. Bytes popped from the host stream out on a valid/ready port tagged with the channel. Bytes taken from a valid/ready source port are pushed toward the host.

The FIFO controls are three active-low strobes: output-enable, read and write. All three come from one 3-bit operation code chosen per state. A pause request holds the engine without ending the transfer, and the transfer resumes where it stopped once the request drops. Between transactions the engine rests in idle and waits for the next header.

Top module: `hostFifoBridge`

## Requirements
- R1: While reset is asserted, and right after it, the output-enable, read and write strobes are all high, `fifoDataOe` is low, and `dnValid` and `upReady` are low.
- R2: The strobes are active-low and driven from a 3-bit code {write, read, output-enable}:
  - pop is 3'b100, meaning output-enable and read are both low while write stays high;
  - push is 3'b011, meaning only write is low;
  - idle is 3'b111.
  - Read and write are never low in the same cycle.
- R3: The first byte of a transaction is a header. Bit 7 gives the direction (1 means fabric-to-host, 0 means host-to-fabric) and bits 6:0 give the channel. The header is followed by a 32-bit byte count, popped as four bytes with the most significant byte first.
- R4: A pop happens only when `fifoNotEmpty` is high. During the data phase it also requires `dnReady` to be high. A push happens only when `fifoNotFull` and `upValid` are both high.
- R5: On a host-to-fabric transfer, every popped data byte appears on `dnData` with `dnValid` high in the cycle of its pop. Bytes appear in FIFO order, and `dnChan` equals the header's channel.
- R6: On a fabric-to-host transfer, each pushed byte is the `upData` value of that cycle. `upReady` is high in exactly the push cycles, and `upChan` equals the header's channel.
- R7: Exactly the given count of data bytes is moved. After that, no further pop or push happens until a new header has been taken from idle.
- R8: A byte count of zero ends the transaction right after the fourth count byte. No data strobe is issued, and the next byte in the FIFO is treated as a new header.
- R9: While `pauseReq` is high, all three strobes stay high. Once `pauseReq` falls, the transfer continues with no data byte lost or repeated.
- R10: `fifoDataOe` is high only in the data phase of a fabric-to-host transfer, and is high in every push cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; the FIFO samples strobes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoDataIn | input | 8 | Byte from the host-to-fabric FIFO |
| fifoDataOut | output | 8 | Byte toward the fabric-to-host FIFO |
| fifoDataOe | output | 1 | Drive enable for the shared data bus |
| fifoNotEmpty | input | 1 | Host-to-fabric FIFO holds at least one byte |
| fifoNotFull | input | 1 | Fabric-to-host FIFO has room |
| fifoOeN | output | 1 | FIFO output-enable strobe, active low |
| fifoRdN | output | 1 | FIFO read strobe, active low |
| fifoWrN | output | 1 | FIFO write strobe, active low |
| pauseReq | input | 1 | Back-pressure: hold the engine with all strobes idle |
| dnData | output | 8 | Data byte toward the fabric |
| dnChan | output | 7 | Channel of the current transfer, downstream side |
| dnValid | output | 1 | `dnData` is valid this cycle |
| dnReady | input | 1 | Fabric sink can take a byte |
| upData | input | 8 | Data byte from the fabric source |
| upChan | output | 7 | Channel of the current transfer, upstream side |
| upValid | input | 1 | `upData` holds a byte |
| upReady | output | 1 | `upData` is taken this cycle |

## Verification
Transactions in both directions are run with different lengths and channels, first with every flag held permissive so the basic byte ordering and channel tagging are exposed. Each direction is then rerun with the sink's ready or the FIFO's not-full flag toggling, with periodic pause bursts, and with a gappy source. These runs separate a correct engine from one that moves a byte without a handshake, drops or repeats a byte around a stall, or miscounts the length. A zero-length transaction and a long pause held in the middle of a read test the early return to idle and the exact resume point.

// File: rtl/hostFifoBridgePkg.sv
package hostFifoBridgePkg;

  localparam int BYTE_W = 8;
  localparam int LEN_W  = 32;

  // Operation codes, bit 0 = output-enable, bit 1 = read, bit 2 = write (all active low)
  localparam logic [2:0] OP_READ  = 3'b100;
  localparam logic [2:0] OP_WRITE = 3'b011;
  localparam logic [2:0] OP_NOP   = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HDR    = 3'd1,
    ST_LEN    = 3'd2,
    ST_TOFAB  = 3'd3,
    ST_TOHOST = 3'd4,
    ST_HOLD   = 3'd5
  } bridgeState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeHdr;
    logic takeLen;
    logic stepLen;
  } dpStrobe_t;

endpackage

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import hostFifoBridgePkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int CNT_W  = LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dp,
  input  logic [DATA_W-1:0] fifoDataIn,
  output logic              dirToHost,
  output logic [DATA_W-2:0] chan,
  output logic              lenIsOne,
  output logic              lenNextZero
);

  localparam int KEEP_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] lenReg;
  logic [CNT_W-1:0] lenShifted;

  assign lenShifted  = {lenReg[KEEP_W-1:0], fifoDataIn};
  assign lenNextZero = (lenShifted == '0);
  assign lenIsOne    = (lenReg == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirToHost <= 1'b0;
      chan      <= '0;
      lenReg    <= '0;
    end else begin
      if (dp.takeHdr) begin
        dirToHost <= fifoDataIn[DATA_W-1];
        chan      <= fifoDataIn[DATA_W-2:0];
        lenReg    <= '0;
      end else if (dp.takeLen) begin
        lenReg <= lenShifted;
      end else if (dp.stepLen) begin
        lenReg <= lenReg - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import hostFifoBridgePkg::*;
#(
  parameter int LEN_BYTES = LEN_W / BYTE_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoNotEmpty,
  input  logic      fifoNotFull,
  input  logic      pauseReq,
  input  logic      dnReady,
  input  logic      upValid,
  input  logic      dirToHost,
  input  logic      lenIsOne,
  input  logic      lenNextZero,
  output logic [2:0] opCode,
  output dpStrobe_t dp,
  output logic      popData,
  output logic      pushData,
  output logic      driveBus
);

  localparam int IDX_W = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN_BYTES - 1);

  bridgeState_t state, stateNext;
  logic [IDX_W-1:0] lenIdx;
  bridgeState_t dataState;

  assign dataState = dirToHost ? ST_TOHOST : ST_TOFAB;
  assign driveBus  = (state == ST_TOHOST);

  always_comb begin
    stateNext = state;
    opCode    = OP_NOP;
    dp        = '0;
    popData   = 1'b0;
    pushData  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fifoNotEmpty && !pauseReq) stateNext = ST_HDR;
      end
      ST_HDR: begin
        if (fifoNotEmpty && !pauseReq) begin
          opCode     = OP_READ;
          dp.takeHdr = 1'b1;
          stateNext  = ST_LEN;
        end
      end
      ST_LEN: begin
        if (fifoNotEmpty && !pauseReq) begin
          opCode     = OP_READ;
          dp.takeLen = 1'b1;
          if (lenIdx == IDX_LAST) stateNext = lenNextZero ? ST_IDLE : dataState;
        end
      end
      ST_TOFAB: begin
        if (pauseReq) begin
          stateNext = ST_HOLD;
        end else if (fifoNotEmpty && dnReady) begin
          opCode     = OP_READ;
          popData    = 1'b1;
          dp.stepLen = 1'b1;
          if (lenIsOne) stateNext = ST_IDLE;
        end
      end
      ST_TOHOST: begin
        if (pauseReq) begin
          stateNext = ST_HOLD;
        end else if (fifoNotFull && upValid) begin
          opCode     = OP_WRITE;
          pushData   = 1'b1;
          dp.stepLen = 1'b1;
          if (lenIsOne) stateNext = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!pauseReq) stateNext = dataState;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lenIdx <= '0;
    end else begin
      state <= stateNext;
      if (dp.takeHdr) lenIdx <= '0;
      else if (dp.takeLen) lenIdx <= (lenIdx == IDX_LAST) ? '0 : lenIdx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/hostFifoBridge.sv
module hostFifoBridge
  import hostFifoBridgePkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int CNT_W  = LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fifoDataIn,
  output logic [DATA_W-1:0] fifoDataOut,
  output logic              fifoDataOe,
  input  logic              fifoNotEmpty,
  input  logic              fifoNotFull,
  output logic              fifoOeN,
  output logic              fifoRdN,
  output logic              fifoWrN,
  input  logic              pauseReq,
  output logic [DATA_W-1:0] dnData,
  output logic [DATA_W-2:0] dnChan,
  output logic              dnValid,
  input  logic              dnReady,
  input  logic [DATA_W-1:0] upData,
  output logic [DATA_W-2:0] upChan,
  input  logic              upValid,
  output logic              upReady
);

  localparam int LEN_BYTES = CNT_W / DATA_W;

  dpStrobe_t         dp;
  logic [2:0]        opCode;
  logic              dirToHost, lenIsOne, lenNextZero;
  logic              popData, pushData, driveBus;
  logic [DATA_W-2:0] chan;

  bridgeCtrl #(.LEN_BYTES(LEN_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .fifoNotEmpty(fifoNotEmpty), .fifoNotFull(fifoNotFull),
    .pauseReq(pauseReq), .dnReady(dnReady), .upValid(upValid),
    .dirToHost(dirToHost), .lenIsOne(lenIsOne), .lenNextZero(lenNextZero),
    .opCode(opCode), .dp(dp), .popData(popData), .pushData(pushData),
    .driveBus(driveBus)
  );

  bridgeDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .dp(dp), .fifoDataIn(fifoDataIn),
    .dirToHost(dirToHost), .chan(chan),
    .lenIsOne(lenIsOne), .lenNextZero(lenNextZero)
  );

  assign fifoOeN     = opCode[0];
  assign fifoRdN     = opCode[1];
  assign fifoWrN     = opCode[2];
  assign fifoDataOut = upData;
  assign fifoDataOe  = driveBus;
  assign dnData      = fifoDataIn;
  assign dnChan      = chan;
  assign dnValid     = popData;
  assign upChan      = chan;
  assign upReady     = pushData;

endmodule

// File: rtl/hostFifoBridgeChecker.sv
module hostFifoBridgeChecker (
  input logic clk,
  input logic rstN,
  input logic fifoOeN,
  input logic fifoRdN,
  input logic fifoWrN,
  input logic fifoNotEmpty,
  input logic fifoNotFull,
  input logic fifoDataOe,
  input logic pauseReq,
  input logic dnValid,
  input logic dnReady,
  input logic upValid,
  input logic upReady
);

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(!fifoRdN && !fifoWrN)); // R2
  AST_RD_WITH_OE: assert property (@(posedge clk) disable iff (!rstN) !fifoRdN |-> !fifoOeN); // R2
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN) !fifoRdN |-> fifoNotEmpty); // R4
  AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rstN) !fifoWrN |-> (fifoNotFull && upValid)); // R4
  AST_DN_ON_POP: assert property (@(posedge clk) disable iff (!rstN) dnValid |-> (!fifoRdN && dnReady)); // R5
  AST_UP_ON_PUSH: assert property (@(posedge clk) disable iff (!rstN) upReady |-> !fifoWrN); // R6
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rstN) pauseReq |-> (fifoRdN && fifoWrN && fifoOeN)); // R9
  AST_BUS_NO_READ: assert property (@(posedge clk) disable iff (!rstN) fifoDataOe |-> fifoRdN); // R10
  AST_PUSH_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rstN) !fifoWrN |-> fifoDataOe); // R10

endmodule

bind hostFifoBridge hostFifoBridgeChecker chk_i (
  .clk(clk), .rstN(rstN), .fifoOeN(fifoOeN), .fifoRdN(fifoRdN), .fifoWrN(fifoWrN),
  .fifoNotEmpty(fifoNotEmpty), .fifoNotFull(fifoNotFull), .fifoDataOe(fifoDataOe),
  .pauseReq(pauseReq), .dnValid(dnValid), .dnReady(dnReady),
  .upValid(upValid), .upReady(upReady)
);

// File: tb/hostFifoBridge_tb_top.sv
module hostFifoBridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // dir[31] chan[30:24] count[23:8] mode[7:0]; mode bit0 toggles ready/not-full, bit1 pause bursts, bit2 gappy source
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b0, 7'd5,   16'd4, 8'd0},
    {1'b0, 7'd127, 16'd9, 8'd1},
    {1'b0, 7'd3,   16'd6, 8'd2},
    {1'b1, 7'd9,   16'd5, 8'd0},
    {1'b1, 7'd66,  16'd8, 8'd3},
    {1'b1, 7'd1,   16'd7, 8'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] fifoDataIn, fifoDataOut, dnData, upData;
  logic [6:0] dnChan, upChan;
  logic fifoDataOe, fifoNotEmpty, fifoOeN, fifoRdN, fifoWrN, dnValid, upValid, upReady;
  logic fifoNotFull = 1'b1, pauseReq = 1'b0, dnReady = 1'b1, upGate = 1'b1;

  logic [7:0] hostMem [256];
  logic [7:0] srcMem  [256];
  logic [7:0] dnGot   [256];
  logic [6:0] dnChanGot [256];
  logic [7:0] outGot  [256];
  logic [6:0] outChanGot [256];
  int popTotal = 0, srcTotal = 0, dnTotal = 0, outTotal = 0;
  int hostBase = 0, hostLen = 0, srcBase = 0, srcLen = 0;
  logic [7:0] hostIdx, srcIdx;
  logic popPend = 1'b0, srcPend = 1'b0;
  logic [2:0] mode = 3'd0;
  logic forcePause = 1'b0;
  logic curToHost = 1'b0;
  int cyc = 0;
  int vioOe = 0, vioBoth = 0, vioEmpty = 0, vioFull = 0, vioPause = 0, vioBus = 0, vioDn = 0;
  int nChecks = 0, nErr = 0;

  assign hostIdx      = 8'(popTotal - hostBase);
  assign srcIdx       = 8'(srcTotal - srcBase);
  assign fifoNotEmpty = (int'(hostIdx) < hostLen);
  assign fifoDataIn   = hostMem[hostIdx];
  assign upValid      = (int'(srcIdx) < srcLen) && upGate;
  assign upData       = srcMem[srcIdx];

  hostFifoBridge dut_i (
    .clk(clk), .rstN(rstN), .fifoDataIn(fifoDataIn), .fifoDataOut(fifoDataOut),
    .fifoDataOe(fifoDataOe), .fifoNotEmpty(fifoNotEmpty), .fifoNotFull(fifoNotFull),
    .fifoOeN(fifoOeN), .fifoRdN(fifoRdN), .fifoWrN(fifoWrN), .pauseReq(pauseReq),
    .dnData(dnData), .dnChan(dnChan), .dnValid(dnValid), .dnReady(dnReady),
    .upData(upData), .upChan(upChan), .upValid(upValid), .upReady(upReady)
  );

  // Input patterns change just after the rising edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    dnReady     = mode[0] ? ((cyc % 3) != 0) : 1'b1;
    fifoNotFull = mode[0] ? ((cyc % 4) != 1) : 1'b1;
    pauseReq    = mode[1] ? ((cyc % 11) >= 8) : forcePause;
    upGate      = mode[2] ? ((cyc % 2) == 0) : 1'b1;
  end

  // Observation at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      popPend = !fifoOeN && !fifoRdN && fifoNotEmpty;
      srcPend = upReady && upValid;
      if (!fifoRdN && fifoOeN) vioOe++;
      if (!fifoRdN && !fifoWrN) vioBoth++;
      if (!fifoRdN && !fifoNotEmpty) vioEmpty++;
      if (!fifoWrN && (!fifoNotFull || !upValid)) vioFull++;
      if (pauseReq && !(fifoRdN && fifoWrN && fifoOeN)) vioPause++;
      if (fifoDataOe && !curToHost) vioBus++;
      if (upReady && fifoWrN) vioBus++;
      if (dnValid) begin
        if (!dnReady || fifoRdN) vioDn++;
        dnGot[dnTotal[7:0]] = dnData;
        dnChanGot[dnTotal[7:0]] = dnChan;
        dnTotal++;
      end
      if (!fifoWrN && fifoNotFull) begin
        if (!fifoDataOe) vioBus++;
        outGot[outTotal[7:0]] = fifoDataOut;
        outChanGot[outTotal[7:0]] = upChan;
        outTotal++;
      end
    end else begin
      popPend = 1'b0;
      srcPend = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (popPend) popTotal <= popTotal + 1;
    if (srcPend) srcTotal <= srcTotal + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fabByte(input int i, input int ch);
    return 8'((i * 37 + ch) % 256);
  endfunction

  function automatic logic [7:0] srcByte(input int i, input int ch);
    return 8'((i * 53 + 7 + ch) % 256);
  endfunction

  int dnBase = 0, outBase = 0, srcStart = 0;

  task automatic loadVec(input bit toHost, input int ch, input int count, input logic [2:0] m);
    logic [31:0] c32;
    c32 = 32'(count);
    mode = m;
    curToHost = toHost;
    dnBase = dnTotal;
    outBase = outTotal;
    srcStart = srcTotal;
    hostMem[0] = {toHost, 7'(ch)};
    hostMem[1] = c32[31:24];
    hostMem[2] = c32[23:16];
    hostMem[3] = c32[15:8];
    hostMem[4] = c32[7:0];
    for (int i = 0; i < count; i++) hostMem[5 + i] = fabByte(i, ch);
    for (int i = 0; i < count + 3; i++) srcMem[i] = srcByte(i, ch);
    srcBase = srcTotal;
    srcLen = toHost ? count + 3 : 0;
    hostBase = popTotal;
    hostLen = 5 + (toHost ? 0 : count);
  endtask

  task automatic finishVec(input bit toHost, input int ch, input int count, input string tag);
    int bad;
    @(negedge clk);
    check(popTotal - hostBase == 5 + (toHost ? 0 : count), {tag, " R7 bytes popped"},
          popTotal - hostBase, 5 + (toHost ? 0 : count));
    if (!toHost) begin
      check(dnTotal - dnBase == count, {tag, " R5 bytes delivered"}, dnTotal - dnBase, count);
      bad = 0;
      for (int i = 0; i < count; i++)
        if (dnGot[8'(dnBase + i)] !== fabByte(i, ch) || dnChanGot[8'(dnBase + i)] !== 7'(ch)) bad++;
      check(bad == 0, {tag, " R5 R3 data/channel mismatches"}, bad, 0);
      check(outTotal == outBase, {tag, " R7 no push on read"}, outTotal - outBase, 0);
    end else begin
      check(outTotal - outBase == count, {tag, " R6 bytes pushed"}, outTotal - outBase, count);
      check(srcTotal - srcStart == count, {tag, " R7 source bytes taken"}, srcTotal - srcStart, count);
      bad = 0;
      for (int i = 0; i < count; i++)
        if (outGot[8'(outBase + i)] !== srcByte(i, ch) || outChanGot[8'(outBase + i)] !== 7'(ch)) bad++;
      check(bad == 0, {tag, " R6 R3 data/channel mismatches"}, bad, 0);
      check(dnTotal == dnBase, {tag, " R7 no delivery on write"}, dnTotal - dnBase, 0);
    end
    check(fifoOeN && fifoRdN && fifoWrN, {tag, " R2 idle code after transfer"},
          int'({fifoWrN, fifoRdN, fifoOeN}), 7);
    check(!fifoDataOe, {tag, " R10 bus released after transfer"}, int'(fifoDataOe), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int snapDn, snapPop;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(fifoOeN && fifoRdN && fifoWrN, "R1 strobes idle in reset", int'({fifoWrN, fifoRdN, fifoOeN}), 7);
    check(!fifoDataOe && !dnValid && !upReady, "R1 outputs low in reset",
          int'({fifoDataOe, dnValid, upReady}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(fifoOeN && fifoRdN && fifoWrN && !fifoDataOe, "R1 idle after reset",
          int'({fifoDataOe, fifoWrN, fifoRdN, fifoOeN}), 7);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      @(posedge clk); #2;
      loadVec(v[31], int'(v[30:24]), int'(v[23:8]), v[2:0]);
      repeat (int'(v[23:8]) * 8 + 60) @(posedge clk);
      finishVec(v[31], int'(v[30:24]), int'(v[23:8]), $sformatf("vec%0d", k));
    end

    // R8: zero-length transaction, then a normal one back to back
    @(posedge clk); #2;
    loadVec(1'b0, 2, 0, 3'd0);
    repeat (40) @(posedge clk);
    finishVec(1'b0, 2, 0, "zero");
    check(dnTotal == dnBase && outTotal == outBase, "R8 zero count moves no data",
          (dnTotal - dnBase) + (outTotal - outBase), 0);
    @(posedge clk); #2;
    loadVec(1'b1, 20, 3, 3'd0);
    repeat (60) @(posedge clk);
    finishVec(1'b1, 20, 3, "afterZero R8");

    // R9: long pause in the middle of a read
    @(posedge clk); #2;
    loadVec(1'b0, 12, 6, 3'd0);
    repeat (9) @(posedge clk);
    #2;
    forcePause = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    snapDn = dnTotal;
    snapPop = popTotal;
    repeat (20) @(negedge clk);
    check(dnTotal == snapDn, "R9 no delivery while paused", dnTotal - snapDn, 0);
    check(popTotal == snapPop, "R9 no pop while paused", popTotal - snapPop, 0);
    check(dnTotal - dnBase > 0 && dnTotal - dnBase < 6, "R9 pause landed mid-transfer",
          dnTotal - dnBase, 3);
    @(posedge clk); #2;
    forcePause = 1'b0;
    repeat (60) @(posedge clk);
    finishVec(1'b0, 12, 6, "pauseMid R9");

    // Protocol monitors over the whole run
    check(vioOe == 0 && vioBoth == 0, "R2 strobe coding", vioOe + vioBoth, 0);
    check(vioEmpty == 0 && vioFull == 0 && vioDn == 0, "R4 flag qualification",
          vioEmpty + vioFull + vioDn, 0);
    check(vioPause == 0, "R9 strobes idle during pause", vioPause, 0);
    check(vioBus == 0, "R10 bus enable confined to pushes phase", vioBus, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule